// File: doc/BRIEF.md
# Block-Cipher Register Frontend

This block sits between a host register bus and a 128-bit block-cipher engine. Software programs a key of up to eight words, a four-word chaining vector, a mode/control word and a system mask word. It then streams payload through a four-word data window. Every four words written into the window form one block. That block is offered to the engine over a valid/ready port. The engine's result is held in an output buffer and read back through the same window.

Two DMA request lines pace transfers one block at a time. Both lines are gated by a start bit. A DMA engine can serve both directions through the single constant window address 0x34. A self-clearing soft reset returns the programmable state to zero. A reset-done flag reports when the block is usable again. The cipher rounds themselves live outside this block.

Top module: `cipher_regfront`

## Requirements
- R1: After reset, the status word (0x4C) reads 1 and the mask word (0x48) reads 0. The control word (0x30) reads 0x02: bit 1 is input-ready and reads 1, bit 0 is output-ready and reads 0. Both DMA requests and the engine valid are low.
- R2: Key word i (0..7) is written and read at byte offset 0x1C - 4*(i XOR 1), so word 0 is at 0x18 and word 1 is at 0x1C. It appears on `coreKey[32*i +: 32]`.
- R3: Chaining words 0..3 sit at 0x20, 0x24, 0x28 and 0x2C in ascending order. Word j appears on `coreIv[32*j +: 32]`.
- R4: Control bits 7:2 are read/write. Bits 4:3 drive `coreKeySize`, bit 5 drives `coreCbc` and bit 2 drives `coreEncrypt`. Bits 1:0 are read-only status, and writes to them have no effect.
- R5: Four data-window writes fill one block, with the first word in bits 31:0. The block is held with `coreInValid` high and unchanged until `coreInReady`.
- R6: While a full block waits for the engine, further data-window writes are ignored.
- R7: A returned block sets control bit 0. The four window reads return its words first-to-last. The fourth read clears bit 0.
- R8: `dmaInReq` is high only when mask bit 5 (start) and mask bit 2 (input DMA enable) are set and the input buffer is not full. It drops in the cycle after the fourth word is written.
- R9: `dmaOutReq` is high when start and mask bit 3 (output DMA enable) are set and a result is held. It drops in the cycle after the fourth word is read.
- R10: Clearing start lowers both requests at once. A block already inside the engine is still captured and can be read.
- R11: Writing 1 to mask bit 1 starts a soft reset. That bit always reads 0. Key, chaining, control and mask words return to 0. The status bit reads 0 for 4 cycles and then 1.
- R12: During a soft reset, bus writes are ignored and reads still return data.
- R13: The revision word at 0x44 is read-only and reads {major[3:0], minor[3:0]} (0x31 by default).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| busWrEn | input | 1 | Register write strobe |
| busRdEn | input | 1 | Register read strobe (consumes a result word) |
| busAddr | input | 8 | Byte offset, word aligned |
| busWrData | input | 32 | Write data |
| busRdData | output | 32 | Read data for busAddr, same cycle |
| coreInValid | output | 1 | Block offered to engine |
| coreInReady | input | 1 | Engine accepts block |
| coreInBlock | output | 128 | Block to engine |
| coreKey | output | 256 | Key words |
| coreIv | output | 128 | Chaining words |
| coreEncrypt | output | 1 | Direction, 1 = encrypt |
| coreCbc | output | 1 | Chained mode select |
| coreKeySize | output | 2 | Key size code |
| coreOutValid | input | 1 | Engine result valid |
| coreOutReady | output | 1 | Result buffer free |
| coreOutBlock | input | 128 | Engine result |
| dmaInReq | output | 1 | Input DMA request |
| dmaOutReq | output | 1 | Output DMA request |

## Verification
The bench targets the following failure modes:
- A swapped key mapping would put word 0 at 0x1C and show a pair-swapped `coreKey`.
- Overwriting a pending block with late window writes would corrupt the block the engine later receives.
- Request lines that miss the fourth-word boundary would either keep `dmaInReq` or `dmaOutReq` high for a fifth beat or drop them after three beats.
- A start bit that discards an in-flight result would leave output-ready low forever.
- A soft reset of the wrong length shows up as a status bit that rises before or after the fourth cycle.
- A design that accepts writes while leaving reset keeps a key word it should have dropped.

// File: rtl/crf_pkg.sv
package crf_pkg;
  localparam int unsigned WORD_W    = 32;
  localparam int unsigned BLK_WORDS = 4;
  localparam int unsigned KEY_WORDS = 8;
  localparam int unsigned IV_WORDS  = 4;
  localparam int unsigned BLK_IDX_W = $clog2(BLK_WORDS);
  localparam int unsigned BLK_W     = WORD_W * BLK_WORDS;

  // word indices (byte offset / 4)
  localparam logic [5:0] W_CTRL  = 6'h0C;
  localparam logic [5:0] W_DATA0 = 6'h0D;
  localparam logic [5:0] W_DATA3 = 6'h10;
  localparam logic [5:0] W_REV   = 6'h11;
  localparam logic [5:0] W_MASK  = 6'h12;
  localparam logic [5:0] W_STAT  = 6'h13;

  // system mask bit positions
  localparam int unsigned MB_START = 5;
  localparam int unsigned MB_OUTEN = 3;
  localparam int unsigned MB_INEN  = 2;
  localparam int unsigned MB_SRST  = 1;
  localparam logic [6:0] MASK_RW = 7'b110_1101;

  typedef struct packed {
    logic                 clearAll;
    logic                 keyWr;
    logic                 ivWr;
    logic                 ctrlWr;
    logic                 maskWr;
    logic                 inWordWr;
    logic [BLK_IDX_W-1:0] inIdx;
    logic                 outCapture;
    logic [BLK_IDX_W-1:0] outIdx;
  } strobe_t;
endpackage

// File: rtl/crf_ctrl.sv
module crf_ctrl
  import crf_pkg::*;
#(
  parameter int unsigned SRST_CYCLES = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       busWrEn,
  input  logic       busRdEn,
  input  logic [7:0] busAddr,
  input  logic       busWrSrst,
  input  logic       maskStart,
  input  logic       maskInEn,
  input  logic       maskOutEn,
  input  logic       coreInReady,
  input  logic       coreOutValid,
  output strobe_t    strb,
  output logic       coreInValid,
  output logic       coreOutReady,
  output logic       dmaInReq,
  output logic       dmaOutReq,
  output logic       inReadyBit,
  output logic       outReadyBit,
  output logic       resetDone
);
  localparam int unsigned CNT_W = $clog2(SRST_CYCLES + 1);
  localparam logic [BLK_IDX_W-1:0] LAST_IDX = BLK_IDX_W'(BLK_WORDS - 1);

  logic [5:0] wIdx;
  logic aligned, isKey, isIv, isCtrl, isData, isMask;
  logic [CNT_W-1:0] srstCnt;
  logic srstActive, srstStart, wrOk, outRd;
  logic inFull, outFull;
  logic [BLK_IDX_W-1:0] inCnt, outCnt;

  assign wIdx    = busAddr[7:2];
  assign aligned = (busAddr[1:0] == 2'b00);
  assign isKey   = aligned && (wIdx < 6'd8);
  assign isIv    = aligned && (wIdx[5:2] == 4'd2);
  assign isCtrl  = aligned && (wIdx == W_CTRL);
  assign isData  = aligned && (wIdx >= W_DATA0) && (wIdx <= W_DATA3);
  assign isMask  = aligned && (wIdx == W_MASK);

  assign srstActive = (srstCnt != '0);
  assign resetDone  = !srstActive;
  assign srstStart  = busWrEn && isMask && busWrSrst && !srstActive;
  assign wrOk       = busWrEn && !srstActive && !srstStart;

  assign strb.clearAll   = srstStart;
  assign strb.keyWr      = wrOk && isKey;
  assign strb.ivWr       = wrOk && isIv;
  assign strb.ctrlWr     = wrOk && isCtrl;
  assign strb.maskWr     = wrOk && isMask;
  assign strb.inWordWr   = wrOk && isData && !inFull;
  assign strb.inIdx      = inCnt;
  assign strb.outCapture = coreOutValid && coreOutReady;
  assign strb.outIdx     = outCnt;

  assign outRd        = busRdEn && isData && outFull;
  assign coreInValid  = inFull;
  assign coreOutReady = !outFull && !srstActive && !srstStart;
  assign inReadyBit   = !inFull;
  assign outReadyBit  = outFull;
  assign dmaInReq     = maskStart && maskInEn && !inFull && !srstActive;
  assign dmaOutReq    = maskStart && maskOutEn && outFull;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      srstCnt <= '0;
    end else if (srstStart) begin
      srstCnt <= CNT_W'(SRST_CYCLES);
    end else if (srstActive) begin
      srstCnt <= srstCnt - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      inCnt  <= '0;
      inFull <= 1'b0;
    end else if (srstStart) begin
      inCnt  <= '0;
      inFull <= 1'b0;
    end else if (strb.inWordWr) begin
      inCnt <= inCnt + 1'b1;
      if (inCnt == LAST_IDX) inFull <= 1'b1;
    end else if (inFull && coreInReady) begin
      inFull <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outCnt  <= '0;
      outFull <= 1'b0;
    end else if (srstStart) begin
      outCnt  <= '0;
      outFull <= 1'b0;
    end else if (strb.outCapture) begin
      outFull <= 1'b1;
      outCnt  <= '0;
    end else if (outRd) begin
      outCnt <= outCnt + 1'b1;
      if (outCnt == LAST_IDX) outFull <= 1'b0;
    end
  end

  // R8
  inreq_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.inWordWr && inCnt == LAST_IDX) |=> !dmaInReq);
  // R9
  outreq_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outRd && outCnt == LAST_IDX) |=> (!dmaOutReq && !outReadyBit));
  // R10
  start_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    !maskStart |-> (!dmaInReq && !dmaOutReq));
  // R11
  srst_begin_chk: assert property (@(posedge clk) disable iff (!rstN)
    srstStart |=> !resetDone);
  // R11
  srst_end_chk: assert property (@(posedge clk) disable iff (!rstN)
    (srstCnt == CNT_W'(1)) |=> resetDone);
endmodule

// File: rtl/crf_dpath.sv
module crf_dpath
  import crf_pkg::*;
#(
  parameter logic [3:0] REV_MAJOR = 4'd3,
  parameter logic [3:0] REV_MINOR = 4'd1
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  strobe_t                   strb,
  input  logic [5:0]                wIdx,
  input  logic [WORD_W-1:0]         busWrData,
  input  logic                      inReadyBit,
  input  logic                      outReadyBit,
  input  logic                      resetDone,
  input  logic                      coreInValid,
  input  logic                      coreInReady,
  input  logic [BLK_W-1:0]          coreOutBlock,
  output logic [WORD_W-1:0]         busRdData,
  output logic [BLK_W-1:0]          coreInBlock,
  output logic [KEY_WORDS*WORD_W-1:0] coreKey,
  output logic [IV_WORDS*WORD_W-1:0]  coreIv,
  output logic                      coreEncrypt,
  output logic                      coreCbc,
  output logic [1:0]                coreKeySize,
  output logic                      maskStart,
  output logic                      maskInEn,
  output logic                      maskOutEn
);
  logic [WORD_W-1:0] keyWords [KEY_WORDS];
  logic [WORD_W-1:0] ivWords  [IV_WORDS];
  logic [WORD_W-1:0] inBuf    [BLK_WORDS];
  logic [WORD_W-1:0] outBuf   [BLK_WORDS];
  logic [5:0] modeReg;
  logic [6:0] maskReg;
  logic [2:0] keyIdx;

  // pair-swapped, descending key placement
  assign keyIdx = (~wIdx[2:0]) ^ 3'd1;

  for (genvar g = 0; g < KEY_WORDS; g++) begin : g_key
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                                  keyWords[g] <= '0;
      else if (strb.clearAll)                     keyWords[g] <= '0;
      else if (strb.keyWr && keyIdx == 3'(g))     keyWords[g] <= busWrData;
    end
    assign coreKey[g*WORD_W +: WORD_W] = keyWords[g];
  end

  for (genvar g = 0; g < IV_WORDS; g++) begin : g_iv
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                                  ivWords[g] <= '0;
      else if (strb.clearAll)                     ivWords[g] <= '0;
      else if (strb.ivWr && wIdx[1:0] == 2'(g))   ivWords[g] <= busWrData;
    end
    assign coreIv[g*WORD_W +: WORD_W] = ivWords[g];
  end

  for (genvar g = 0; g < BLK_WORDS; g++) begin : g_blk
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        inBuf[g]  <= '0;
        outBuf[g] <= '0;
      end else begin
        if (strb.inWordWr && strb.inIdx == BLK_IDX_W'(g)) inBuf[g] <= busWrData;
        if (strb.outCapture) outBuf[g] <= coreOutBlock[g*WORD_W +: WORD_W];
      end
    end
    assign coreInBlock[g*WORD_W +: WORD_W] = inBuf[g];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeReg <= '0;
      maskReg <= '0;
    end else if (strb.clearAll) begin
      modeReg <= '0;
      maskReg <= '0;
    end else begin
      if (strb.ctrlWr) modeReg <= busWrData[7:2];
      if (strb.maskWr) maskReg <= busWrData[6:0] & MASK_RW;
    end
  end

  assign coreKeySize = modeReg[2:1];
  assign coreEncrypt = modeReg[0];
  assign coreCbc     = modeReg[3];
  assign maskStart   = maskReg[MB_START];
  assign maskInEn    = maskReg[MB_INEN];
  assign maskOutEn   = maskReg[MB_OUTEN];

  always_comb begin
    busRdData = '0;
    if (wIdx < 6'd8) begin
      busRdData = keyWords[keyIdx];
    end else if (wIdx[5:2] == 4'd2) begin
      busRdData = ivWords[wIdx[1:0]];
    end else if (wIdx >= W_DATA0 && wIdx <= W_DATA3) begin
      if (outReadyBit) busRdData = outBuf[strb.outIdx];
    end else begin
      case (wIdx)
        W_CTRL:  busRdData = {24'd0, modeReg, inReadyBit, outReadyBit};
        W_REV:   busRdData = {24'd0, REV_MAJOR, REV_MINOR};
        W_MASK:  busRdData = {25'd0, maskReg};
        W_STAT:  busRdData = {31'd0, resetDone};
        default: busRdData = '0;
      endcase
    end
  end

  // R5
  blk_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (coreInValid && !coreInReady && !strb.clearAll) |=> (coreInValid && $stable(coreInBlock)));
  // R4
  mode_keep_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.ctrlWr && !strb.clearAll) |=> $stable(modeReg));
endmodule

// File: rtl/cipher_regfront.sv
module cipher_regfront
  import crf_pkg::*;
#(
  parameter int unsigned SRST_CYCLES = 4,
  parameter logic [3:0]  REV_MAJOR   = 4'd3,
  parameter logic [3:0]  REV_MINOR   = 4'd1
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         busWrEn,
  input  logic         busRdEn,
  input  logic [7:0]   busAddr,
  input  logic [31:0]  busWrData,
  output logic [31:0]  busRdData,
  output logic         coreInValid,
  input  logic         coreInReady,
  output logic [127:0] coreInBlock,
  output logic [255:0] coreKey,
  output logic [127:0] coreIv,
  output logic         coreEncrypt,
  output logic         coreCbc,
  output logic [1:0]   coreKeySize,
  input  logic         coreOutValid,
  output logic         coreOutReady,
  input  logic [127:0] coreOutBlock,
  output logic         dmaInReq,
  output logic         dmaOutReq
);
  strobe_t strb;
  logic maskStart, maskInEn, maskOutEn;
  logic inReadyBit, outReadyBit, resetDone;

  crf_ctrl #(.SRST_CYCLES(SRST_CYCLES)) ctrl_i (
    .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busRdEn(busRdEn),
    .busAddr(busAddr), .busWrSrst(busWrData[MB_SRST]),
    .maskStart(maskStart), .maskInEn(maskInEn), .maskOutEn(maskOutEn),
    .coreInReady(coreInReady), .coreOutValid(coreOutValid), .strb(strb),
    .coreInValid(coreInValid), .coreOutReady(coreOutReady),
    .dmaInReq(dmaInReq), .dmaOutReq(dmaOutReq), .inReadyBit(inReadyBit),
    .outReadyBit(outReadyBit), .resetDone(resetDone)
  );

  crf_dpath #(.REV_MAJOR(REV_MAJOR), .REV_MINOR(REV_MINOR)) dpath_i (
    .clk(clk), .rstN(rstN), .strb(strb), .wIdx(busAddr[7:2]),
    .busWrData(busWrData), .inReadyBit(inReadyBit), .outReadyBit(outReadyBit),
    .resetDone(resetDone), .coreInValid(coreInValid), .coreInReady(coreInReady),
    .coreOutBlock(coreOutBlock), .busRdData(busRdData), .coreInBlock(coreInBlock),
    .coreKey(coreKey), .coreIv(coreIv), .coreEncrypt(coreEncrypt), .coreCbc(coreCbc),
    .coreKeySize(coreKeySize), .maskStart(maskStart), .maskInEn(maskInEn),
    .maskOutEn(maskOutEn)
  );
endmodule

// File: tb/cipher_regfront_tb_top.sv
module cipher_regfront_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic busWrEn = 1'b0, busRdEn = 1'b0;
  logic [7:0] busAddr = '0;
  logic [31:0] busWrData = '0;
  logic [31:0] busRdData;
  logic coreInValid, coreOutReady, coreEncrypt, coreCbc, dmaInReq, dmaOutReq;
  logic coreInReady, coreOutValid;
  logic [127:0] coreInBlock, coreOutBlock, coreIv;
  logic [255:0] coreKey;
  logic [1:0] coreKeySize;

  int nChecks = 0, nFails = 0;
  logic [127:0] inQ[$];
  logic [127:0] outQ[$];
  logic [127:0] keyLow;

  always #4 clk = ~clk;

  cipher_regfront dut_i (.*);

  // engine stand-in: fixed latency, result = block ^ low key half
  localparam int LAT = 3;
  logic stubBusy = 1'b0;
  int stubCnt = 0;
  logic [127:0] stubHold = '0;
  assign coreInReady  = !stubBusy;
  assign coreOutValid = stubBusy && (stubCnt == 0);
  assign coreOutBlock = stubHold;
  always @(posedge clk) begin
    if (!stubBusy && coreInValid) begin
      stubBusy <= 1'b1;
      stubCnt  <= LAT;
      stubHold <= coreInBlock ^ coreKey[127:0];
    end else if (stubBusy && stubCnt != 0) begin
      stubCnt <= stubCnt - 1;
    end else if (coreOutValid && coreOutReady) begin
      stubBusy <= 1'b0;
    end
  end

  task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic busWrite(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    busWrEn = 1'b1; busAddr = a; busWrData = d;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic busRead(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    busRdEn = 1'b1; busAddr = a;
    #1 d = busRdData;
    @(negedge clk);
    busRdEn = 1'b0;
  endtask

  // driver: push expected core input and expected result, then write
  task automatic writeBlock(input logic [127:0] blk);
    inQ.push_back(blk);
    outQ.push_back(blk ^ keyLow);
    for (int w = 0; w < 4; w++) busWrite(8'h34, blk[w*32 +: 32]);
  endtask

  task automatic waitOut();
    logic [31:0] v;
    for (int t = 0; t < 40; t++) begin
      busRead(8'h30, v);
      if (v[0]) break;
    end
  endtask

  task automatic readBlock(input string tag);
    logic [31:0] v;
    logic [127:0] got;
    logic [127:0] exp;
    waitOut();
    exp = (outQ.size() != 0) ? outQ.pop_front() : 'x;
    for (int w = 0; w < 4; w++) begin
      busRead(8'h34 + 8'(4 * w), v);
      got[w*32 +: 32] = v;
    end
    chk(tag, got, exp);
  endtask

  // monitor: blocks offered to the engine, checked in order (R5, R6)
  always @(negedge clk) begin
    if (rstN && coreInValid && coreInReady) begin
      if (inQ.size() == 0) chk("R5 unexpected block", coreInBlock, 'x);
      else chk("R5 R6 block to engine", coreInBlock, inQ.pop_front());
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1
    chk("R1 dma reqs", {dmaInReq, dmaOutReq, coreInValid}, 0);
    busRead(8'h4C, v); chk("R1 status", v, 1);
    busRead(8'h30, v); chk("R1 control", v, 32'h2);
    busRead(8'h48, v); chk("R1 mask", v, 0);
    // R13
    busRead(8'h44, v); chk("R13 revision", v, 32'h31);
    busWrite(8'h44, 32'hFF); busRead(8'h44, v); chk("R13 revision read-only", v, 32'h31);

    // R2
    for (int i = 0; i < 8; i++) busWrite(8'(32'h1C - ((i ^ 1) * 4)), 32'hC0DE_0000 + i);
    for (int i = 0; i < 8; i++) chk("R2 key placement", coreKey[i*32 +: 32], 32'hC0DE_0000 + i);
    busRead(8'h18, v); chk("R2 key word0 at 0x18", v, 32'hC0DE_0000);
    busRead(8'h00, v); chk("R2 key word6 at 0x00", v, 32'hC0DE_0006);
    keyLow = {32'hC0DE_0003, 32'hC0DE_0002, 32'hC0DE_0001, 32'hC0DE_0000};

    // R3
    for (int j = 0; j < 4; j++) busWrite(8'(8'h20 + 4 * j), 32'h1F00_0000 + j);
    chk("R3 chaining words", coreIv, {32'h1F00_0003, 32'h1F00_0002, 32'h1F00_0001, 32'h1F00_0000});

    // R4
    busWrite(8'h30, 32'hFF);
    busRead(8'h30, v); chk("R4 control readback", v, 32'hFE);
    chk("R4 mode outputs", {coreKeySize, coreCbc, coreEncrypt}, 4'b1111);
    busWrite(8'h30, 32'h08);
    chk("R4 128-bit decrypt", {coreKeySize, coreCbc, coreEncrypt}, 4'b0100);

    // R8 R5 R7 R9 with DMA pacing
    busWrite(8'h48, 32'h2C);
    chk("R8 in request raised", dmaInReq, 1);
    inQ.push_back(128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3210);
    outQ.push_back(128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3210 ^ keyLow);
    for (int w = 0; w < 4; w++) begin
      busWrite(8'h34, inQ[0][w*32 +: 32]);
      chk("R8 in request per word", dmaInReq, (w == 3) ? 1'b0 : 1'b1);
    end
    waitOut();
    busRead(8'h30, v); chk("R7 output ready set", v[0], 1);
    chk("R9 out request raised", dmaOutReq, 1);
    begin
      logic [127:0] got;
      logic [127:0] exp;
      exp = outQ.pop_front();
      for (int w = 0; w < 4; w++) begin
        busRead(8'h34, v);
        got[w*32 +: 32] = v;
        chk("R9 out request per word", dmaOutReq, (w == 3) ? 1'b0 : 1'b1);
      end
      chk("R7 result words in order", got, exp);
    end
    busRead(8'h30, v); chk("R7 output ready cleared", v[0], 0);

    // R6: pending block ignores extra writes
    writeBlock(128'hAAAA_0001_AAAA_0002_AAAA_0003_AAAA_0004);
    repeat (6) @(negedge clk);
    writeBlock(128'hBBBB_0001_BBBB_0002_BBBB_0003_BBBB_0004);
    repeat (6) @(negedge clk);
    writeBlock(128'hCCCC_0001_CCCC_0002_CCCC_0003_CCCC_0004);
    busRead(8'h30, v); chk("R6 input not ready", v[1], 0);
    for (int w = 0; w < 4; w++) busWrite(8'h34, 32'hDEAD_BEEF);
    readBlock("R7 first result");
    readBlock("R7 second result");
    readBlock("R6 pending block intact");

    // R10: clear start while block is inside the engine
    busWrite(8'h48, 32'h2C);
    writeBlock(128'h5555_6666_7777_8888_9999_AAAA_BBBB_CCCC);
    busWrite(8'h48, 32'h0C);
    chk("R10 requests drop", {dmaInReq, dmaOutReq}, 0);
    waitOut();
    chk("R10 out request stays low", dmaOutReq, 0);
    readBlock("R10 in-flight result kept");

    // R11
    busWrite(8'h48, 32'h2C);
    busWrite(8'h48, 32'h02);
    busRdEn = 1'b1; busAddr = 8'h4C;
    for (int k = 0; k < 5; k++) begin
      #1 chk("R11 reset-done timing", busRdData, (k < 4) ? 0 : 1);
      @(negedge clk);
    end
    busRdEn = 1'b0;
    busRead(8'h18, v); chk("R11 key cleared", v, 0);
    busRead(8'h24, v); chk("R11 chaining cleared", v, 0);
    busRead(8'h30, v); chk("R11 control cleared", v, 32'h2);
    busRead(8'h48, v); chk("R11 mask cleared, soft-reset bit reads 0", v, 0);
    chk("R11 no requests", {dmaInReq, dmaOutReq}, 0);

    // R12
    busWrite(8'h48, 32'h02);
    busWrite(8'h18, 32'h5555_5555);
    busRead(8'h44, v); chk("R12 read during soft reset", v, 32'h31);
    repeat (6) @(negedge clk);
    busRead(8'h18, v); chk("R12 write ignored in soft reset", v, 0);

    chk("R5 queue drained", 128'(inQ.size()), 0);
    $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule